// File: doc/BRIEF.md
# Boundary-Scan Ring with Test-Clock Stepping

This block places a ring of scan cells around a small core. One cell sits on the system reset input, one on each core input and one on each core output. Every cell has a shift stage, which belongs to the serial chain from `tdi` to `tdo`, and an update latch, which holds a parallel value. An external TAP controller drives the block. It supplies the capture, shift and update strobes, a two-bit mode code and a flag that is high while it sits in Run-Test/Idle. All of these are sampled on the rising edge of `tck`.

In the pass-through modes, each cell connects its pin straight to the core. The sample mode takes a snapshot of the pins without disturbing the core. The external-test mode drives the output pins from the update latches. The internal-test mode feeds the core inputs and the core reset from the update latches and captures the core outputs. In internal test the core clock is taken from `tck` and pulses only while the TAP sits in Run-Test/Idle, so the core can be advanced one clock at a time.

A clock-handover state machine runs in the `tck` domain and moves the core clock between the two sources:
- SYS: the system clock runs. It goes to SYS_DRAIN when internal test is selected.
- SYS_DRAIN: the system clock request is dropped. It goes to TEST once the synchronised acknowledge reads low.
- TEST: the test clock gate follows the idle flag. It goes to TEST_DRAIN when internal test is deselected.
- TEST_DRAIN: the test gate closes. It always moves on to SYS_FILL after one cycle.
- SYS_FILL: the system clock is requested again. It goes to SYS once the acknowledge reads high.

The system reset reaches the core only after `trst_n` has initialised the reset cell.

Top module: `bscan_ring`

## Requirements
- R1: The chain holds 1+N_IN+N_OUT bits. Bit 0 is the reset cell, bits 1..N_IN are the input cells and the bits above them are the output cells. Each shift strobe moves every bit one place toward bit 0 and loads `tdi` into the top bit. `tdo` always shows bit 0, so a vector shifted in LSB first reappears on `tdo` in the same order during the next shift pass.
- R2: Mode codes are 0 for pass-through, 1 for sample, 2 for external test and 3 for internal test. In modes 0 and 1, after TRST: `core_in` equals `pin_in`, `pin_out` equals `core_out` and `core_rst_n` equals `pin_rst_n`, whatever the update latches hold.
- R3: In modes 0, 1 and 2, a capture strobe loads `pin_rst_n` into bit 0, `pin_in` into the input bits and `core_out` into the output bits.
- R4: In mode 2, `pin_out` is driven from the output-cell update latches and holds its value while no update strobe arrives.
- R5: In mode 3, `core_in` and `core_rst_n` come from the update latches whatever `pin_in` and `pin_rst_n` do. A capture strobe reloads the reset and input bits from their own update latches and loads `core_out` into the output bits.
- R6: Update latches change only on an update strobe. Shift stages change only on a capture or shift strobe, and capture wins when both are present.
- R7: While `trst_n` is low, every shift stage is 0, the input and output update latches are 0 and the reset-cell latch is 1, which means reset deasserted.
- R8: Before `trst_n` has been asserted for the first time, `core_rst_n` is not 1, whatever `pin_rst_n` is.
- R9: In mode 3, once the handover has settled, the core clock gives exactly one rising edge per `tck` cycle during which the idle flag is high, and no edge while it is low.
- R10: The system-clock gate and the test-clock gate are never open together. Handover passes through the SYS, SYS_DRAIN, TEST, TEST_DRAIN and SYS_FILL states, and both gates change only while their own clock is low.
- R11: In modes 0, 1 and 2, the core clock follows `sys_clk` once the handover has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (chain bit 0) |
| mode | input | 2 | Mode code from the TAP instruction (0 pass-through, 1 sample, 2 external test, 3 internal test) |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tap_idle | input | 1 | High while the TAP is in Run-Test/Idle |
| sys_clk | input | 1 | System clock |
| pin_rst_n | input | 1 | System reset pin, active low |
| pin_in | input | N_IN | Input pins |
| pin_out | output | N_OUT | Output pins |
| core_in | output | N_IN | Inputs driven into the core |
| core_out | input | N_OUT | Outputs from the core |
| core_rst_n | output | 1 | Reset driven into the core, active low |
| core_clk | output | 1 | Core master clock |

## Verification
The hold properties on the ports take for granted that the mode code changes only between strobes and that `trst_n` is not pulsed between two `tck` edges. The bench therefore drives every input one nanosecond after a `tck` rising edge and holds it for the whole cycle. The idle-flag stepping check counts on the flag being steady across each falling edge of `tck`. Random pins, latch contents and step values are drawn from a fixed seed and kept within these limits. The bench adds directed cases for the reset-gating corner, the handover waits and the length of the chain.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_SAMPLE = 2'd1,
        MODE_EXTEST = 2'd2,
        MODE_INTEST = 2'd3
    } bsr_mode_e;

    typedef enum logic [2:0] {
        CK_SYS        = 3'd0,
        CK_SYS_DRAIN  = 3'd1,
        CK_TEST       = 3'd2,
        CK_TEST_DRAIN = 3'd3,
        CK_SYS_FILL   = 3'd4
    } clk_state_e;

endpackage

// File: rtl/bsr_cell.sv
`timescale 1ns/1ps
module bsr_cell #(
    parameter logic UPD_RESET = 1'b0
) (
    input  logic tck,
    input  logic trst_n,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic cap_d,
    input  logic ser_in,
    output logic ser_q,
    output logic upd_q
);

    // shift stage: capture has priority over shift
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            ser_q <= 1'b0;
        else if (capture)
            ser_q <= cap_d;
        else if (shift)
            ser_q <= ser_in;
    end

    // parallel update latch
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            upd_q <= UPD_RESET;
        else if (update)
            upd_q <= ser_q;
    end

    assert_shift_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !(capture || shift) |=> $stable(ser_q));

    assert_upd_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !update |=> $stable(upd_q));

endmodule

// File: rtl/bsr_clk_switch.sv
`timescale 1ns/1ps
module bsr_clk_switch
    import bsr_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic tck,
    input  logic trst_n,
    input  logic sys_clk,
    input  logic test_sel,
    input  logic tap_idle,
    output logic core_clk
);

    clk_state_e state_q, state_d;
    logic sys_req;
    logic test_gate_req;
    logic [SYNC_DEPTH-1:0] req_sync;
    logic [SYNC_DEPTH-1:0] ack_sync;
    logic sys_en;
    logic tck_en;
    logic sys_ack;

    assign sys_ack = ack_sync[SYNC_DEPTH-1];

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            state_q <= CK_SYS;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_SYS:        if (test_sel) state_d = CK_SYS_DRAIN;
            CK_SYS_DRAIN:  if (!sys_ack) state_d = CK_TEST;
            CK_TEST:       if (!test_sel) state_d = CK_TEST_DRAIN;
            CK_TEST_DRAIN: state_d = CK_SYS_FILL;
            CK_SYS_FILL:   if (sys_ack) state_d = CK_SYS;
            default:       state_d = CK_SYS;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        sys_req       = 1'b0;
        test_gate_req = 1'b0;
        unique case (state_q)
            CK_SYS:        sys_req = 1'b1;
            CK_SYS_DRAIN:  sys_req = 1'b0;
            CK_TEST:       test_gate_req = tap_idle;
            CK_TEST_DRAIN: test_gate_req = 1'b0;
            CK_SYS_FILL:   sys_req = 1'b1;
            default:       sys_req = 1'b1;
        endcase
    end

    // request into the system clock domain
    always_ff @(posedge sys_clk or negedge trst_n) begin
        if (!trst_n)
            req_sync <= '1;
        else
            req_sync <= {req_sync[SYNC_DEPTH-2:0], sys_req};
    end

    // system gate enable changes only while sys_clk is low
    always_ff @(negedge sys_clk or negedge trst_n) begin
        if (!trst_n)
            sys_en <= 1'b1;
        else
            sys_en <= req_sync[SYNC_DEPTH-1];
    end

    // acknowledge back into the test clock domain
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            ack_sync <= '1;
        else
            ack_sync <= {ack_sync[SYNC_DEPTH-2:0], sys_en};
    end

    // test gate enable changes only while tck is low
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            tck_en <= 1'b0;
        else
            tck_en <= test_gate_req;
    end

    assign core_clk = (sys_clk & sys_en) | (tck & tck_en);

    assert_gates_exclusive_R10: assert property (@(posedge tck) disable iff (!trst_n)
        !(sys_en && tck_en));

    assert_test_gate_state_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != CK_TEST) |-> !tck_en);

endmodule

// File: rtl/bscan_ring.sv
`timescale 1ns/1ps
module bscan_ring
    import bsr_pkg::*;
#(
    parameter int N_IN       = 8,
    parameter int N_OUT      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    output logic             tdo,
    input  logic [1:0]       mode,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tap_idle,
    input  logic             sys_clk,
    input  logic             pin_rst_n,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic             core_rst_n,
    output logic             core_clk
);

    localparam int CHAIN_LEN = 1 + N_IN + N_OUT;
    localparam int OUT_BASE  = 1 + N_IN;

    bsr_mode_e mode_e;
    logic      intest;
    logic      extest;
    logic      init_ok;
    logic [CHAIN_LEN:0]   link;
    logic                 upd_rst;
    logic [N_IN-1:0]      upd_in;
    logic [N_OUT-1:0]     upd_out;

    assign mode_e = bsr_mode_e'(mode);
    assign intest = (mode_e == MODE_INTEST);
    assign extest = (mode_e == MODE_EXTEST);
    assign link[CHAIN_LEN] = tdi;
    assign tdo = link[0];

    // set once TRST has initialised the reset cell
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            init_ok <= 1'b1;
        else
            init_ok <= init_ok;
    end

    // reset cell, chain bit 0
    bsr_cell #(.UPD_RESET(1'b1)) u_rst_cell (
        .tck     (tck),
        .trst_n  (trst_n),
        .capture (capture_dr),
        .shift   (shift_dr),
        .update  (update_dr),
        .cap_d   (intest ? upd_rst : pin_rst_n),
        .ser_in  (link[1]),
        .ser_q   (link[0]),
        .upd_q   (upd_rst)
    );

    // input cells, chain bits 1..N_IN
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        bsr_cell #(.UPD_RESET(1'b0)) u_cell (
            .tck     (tck),
            .trst_n  (trst_n),
            .capture (capture_dr),
            .shift   (shift_dr),
            .update  (update_dr),
            .cap_d   (intest ? upd_in[gi] : pin_in[gi]),
            .ser_in  (link[gi + 2]),
            .ser_q   (link[gi + 1]),
            .upd_q   (upd_in[gi])
        );
        assign core_in[gi] = intest ? upd_in[gi] : pin_in[gi];
    end

    // output cells, chain bits OUT_BASE..CHAIN_LEN-1
    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        bsr_cell #(.UPD_RESET(1'b0)) u_cell (
            .tck     (tck),
            .trst_n  (trst_n),
            .capture (capture_dr),
            .shift   (shift_dr),
            .update  (update_dr),
            .cap_d   (core_out[go]),
            .ser_in  (link[OUT_BASE + go + 1]),
            .ser_q   (link[OUT_BASE + go]),
            .upd_q   (upd_out[go])
        );
        assign pin_out[go] = extest ? upd_out[go] : core_out[go];
    end

    assign core_rst_n = intest ? upd_rst : (pin_rst_n & init_ok);

    bsr_clk_switch #(.SYNC_DEPTH(SYNC_DEPTH)) u_clk_switch (
        .tck      (tck),
        .trst_n   (trst_n),
        .sys_clk  (sys_clk),
        .test_sel (intest),
        .tap_idle (tap_idle),
        .core_clk (core_clk)
    );

    assert_intest_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (intest && !update_dr) |=> (!intest || ($stable(core_in) && $stable(core_rst_n))));

    assert_extest_hold_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (extest && !update_dr) |=> (!extest || $stable(pin_out)));

endmodule

// File: tb/bscan_ring_tb.sv
`timescale 1ns/1ps
module bscan_ring_tb;

    localparam int NI = 8;
    localparam int NO = 8;
    localparam int L  = 1 + NI + NO;

    logic tck = 1'b0, sys_clk = 1'b0, trst_n = 1'b1, tdi = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tap_idle = 1'b0;
    logic pin_rst_n = 1'b1;
    logic [1:0] mode = 2'd0;
    logic [NI-1:0] pin_in = '0;
    logic [NO-1:0] pin_out, core_out;
    logic [NI-1:0] core_in;
    logic tdo, core_rst_n, core_clk;
    logic [7:0] acc;
    int errors = 0, checks = 0, pulses = 0;

    always #2 tck = ~tck;
    always #3.5 sys_clk = ~sys_clk;

    // core model: accumulator stepped by the core clock
    always @(posedge core_clk or negedge core_rst_n)
        if (!core_rst_n) acc <= '0;
        else acc <= acc + core_in;
    assign core_out = acc;
    always @(posedge core_clk) pulses = pulses + 1;

    bscan_ring #(.N_IN(NI), .N_OUT(NO)) u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo), .mode(mode),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tap_idle(tap_idle), .sys_clk(sys_clk), .pin_rst_n(pin_rst_n),
        .pin_in(pin_in), .pin_out(pin_out), .core_in(core_in),
        .core_out(core_out), .core_rst_n(core_rst_n), .core_clk(core_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout);
        for (int i = 0; i < L; i++) begin
            vout[i] = tdo;
            tdi = vin[i];
            shift_dr = 1'b1;
            tick();
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
    endtask

    function automatic logic [L-1:0] exp_cap(input logic in_test, input logic prst,
            input logic [NI-1:0] pins, input logic [NO-1:0] cout, input logic [L-1:0] upd);
        if (in_test) return {cout, upd[NI:1], upd[0]};
        return {cout, pins, prst};
    endfunction

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [L-1:0] v, v2, got, lat;
        logic [NO-1:0] p, cap_out;
        logic [NI-1:0] cap_in, k;
        logic cap_rst;
        int base;
        void'($urandom(32'h1F2E3D));

        // R8: before the first TRST, reset does not reach the core
        #1;
        chk("R8 pre-trst core_rst_n", {31'd0, core_rst_n === 1'b1}, 32'd0);
        trst_n = 1'b0;
        repeat (3) tick();
        chk("R7 tdo in trst", tdo, 0);
        trst_n = 1'b1;
        tick();

        // R7: reset state of the latches and shift stages
        mode = 2'd2;
        tick();
        chk("R7 pin_out latches cleared", pin_out, 0);
        mode = 2'd3;
        tick();
        chk("R7 core_in latches cleared", core_in, 0);
        chk("R7 reset latch deasserted", core_rst_n, 1);
        mode = 2'd0;
        shift_vec('0, got);
        chk("R7 shift stages cleared", got, 0);
        repeat (25) tick();
        chk("R8 reset passes after trst", core_rst_n, 1);

        // R1: chain length and order
        v = L'($urandom());
        shift_vec(v, got);
        v2 = L'($urandom());
        shift_vec(v2, got);
        chk("R1 chain order", got, v);

        // R2: pass-through with random latch contents
        for (int it = 0; it < 6; it++) begin
            mode = 2'($urandom_range(0, 1));
            shift_vec(L'($urandom()), got);
            do_update();
            pin_in = NI'($urandom());
            pin_rst_n = (it != 3);
            tick();
            chk("R2 core_in passthrough", core_in, pin_in);
            chk("R2 pin_out passthrough", pin_out, core_out);
            chk("R2 reset passthrough", core_rst_n, pin_rst_n);
        end

        // R3 and R6: sample capture, shift stage holds afterwards
        mode = 2'd1;
        for (int it = 0; it < 4; it++) begin
            pin_rst_n = (it == 3);
            pin_in = (it == 3) ? '0 : NI'($urandom());
            tick();
            tick();
            cap_rst = pin_rst_n; cap_in = pin_in; cap_out = core_out;
            do_capture();
            pin_in = NI'($urandom());
            pin_rst_n = 1'b0;
            repeat (3) tick();
            shift_vec(L'($urandom()), got);
            chk("R3 sample capture (R6 hold)", got, exp_cap(1'b0, cap_rst, cap_in, cap_out, '0));
        end

        // R4: external test drives pins from latches, capture sees pins
        mode = 2'd2;
        pin_rst_n = 1'b0;
        for (int it = 0; it < 3; it++) begin
            p = NO'($urandom());
            v = {p, NI'($urandom()), 1'b1};
            shift_vec(v, got);
            do_update();
            chk("R4 pin_out from latches", pin_out, p);
            pin_in = NI'($urandom());
            tick();
            cap_in = pin_in;
            do_capture();
            shift_vec(L'($urandom()), got);
            chk("R4 extest capture", got, exp_cap(1'b0, 1'b0, cap_in, '0, '0));
            chk("R6 latch holds through shift", pin_out, p);
        end

        // R5 and R9: internal test, stepping from tck
        mode = 2'd1;
        pin_in = '0;
        pin_rst_n = 1'b1;
        k = NI'($urandom_range(1, 255));
        shift_vec({NO'(0), k, 1'b0}, got);
        do_update();
        mode = 2'd3;
        repeat (16) tick();
        pin_in = NI'($urandom());
        pin_rst_n = 1'b1;
        tick();
        chk("R5 core_in from latches", core_in, k);
        chk("R5 core reset from latch", core_rst_n, 0);
        base = pulses;
        lat = {NO'(0), k, 1'b1};
        shift_vec(lat, got);
        do_update();
        pin_rst_n = 1'b0;
        tick();
        chk("R5 reset latch released", core_rst_n, 1);
        chk("R9 no pulses outside idle", pulses - base, 0);
        chk("R9 core held", core_out, 0);
        base = pulses;
        tap_idle = 1'b1;
        repeat (5) tick();
        tap_idle = 1'b0;
        repeat (2) tick();
        chk("R9 five steps", pulses - base, 5);
        chk("R9 core after five steps", core_out, 8'(k * 5));
        tap_idle = 1'b1;
        repeat (3) tick();
        tap_idle = 1'b0;
        pin_in = NI'($urandom());
        repeat (2) tick();
        chk("R9 eight steps", core_out, 8'(k * 8));
        chk("R5 core_in ignores pins", core_in, k);
        do_capture();
        shift_vec(L'($urandom()), got);
        chk("R5 intest capture", got, exp_cap(1'b1, 1'b0, '0, 8'(k * 8), lat));

        // R10 and R11: return to the system clock
        mode = 2'd0;
        pin_rst_n = 1'b1;
        repeat (25) tick();
        base = pulses;
        repeat (20) tick();
        chk("R11 system clock resumed", {31'd0, (pulses - base >= 9) && (pulses - base <= 13)}, 1);

        // R7: late TRST clears driven pins
        mode = 2'd2;
        shift_vec({NO'(8'hA5), NI'(0), 1'b1}, got);
        do_update();
        chk("R4 pattern before trst", pin_out, 8'hA5);
        trst_n = 1'b0;
        tick();
        chk("R7 trst clears pin latches", pin_out, 0);
        trst_n = 1'b1;
        tick();

        finish_up();
    end

endmodule